// File: doc/BRIEF.md
# Bus Access Cycle Stretcher

This block sits between a 16-bit processor core and its memory system and decides how many bus cycles each access takes. The core presents one request with an address, a byte or word size, a direction, an access kind and a region code. The block plans the access from these fields. It may split a word into two byte cycles, add wait states for a slow chip-select region, or run a free cycle that drives no strobe. It then drives the memory-side strobe, address and write data cycle by cycle. It ends with a one-cycle done pulse that carries the assembled read data.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and its fields are sampled only on that edge. `req_ready` is high only while the block is idle. It falls from the edge after acceptance through the done cycle, so the core must hold or re-present its request until ready returns. Whatever it drives on the request pins in the meantime has no effect. The memory side has no back-pressure. Slow regions get their wait count from the configuration inputs, one 2-bit field per chip-select.

Top module: `bus_stretch_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request held on the pins while the block is busy does not change the ongoing bus cycles, and it is not taken until idle returns. In idle, `mem_en` and `done` are low.
- R2: Region code 0 (internal RAM) runs any word access, aligned or at an odd address, as one word cycle (`mem_byte`=0) at the given address with no wait states. A byte access there takes one byte cycle.
- R3: Region code 1 (8-bit external bus) splits every word access into two byte cycles. The first is at address A and carries the high byte (write data bits 15:8, read data into result bits 15:8). The second is at A+1 and carries the low byte. A byte access takes one byte cycle. Byte cycles use `mem_wdata[7:0]` and `mem_rdata[7:0]`.
- R4: A word access at an odd address to region 2 (slow chip-select) or region 3 (16-bit external) is split into two byte cycles in the R3 order. An even-address word there takes one word cycle.
- R5: In region 2, every bus cycle of a strobing access lasts 1+W clocks. W is the 2-bit field of `cfg_waits` picked by `req_cs`: field i is bits [2i+1:2i]. Strobe, address and write data stay steady throughout.
- R6: Kind code 2 (vector fetch) is always a word read at the address with bit 0 cleared. It is still split per R3 in region 1.
- R7: Kind code 4 (free), and kind code 3 (conditional) with `req_cond_real`=0, take exactly one clock with `mem_en` low and no wait states, and return read data 0.
- R8: Kind code 3 with `req_cond_real`=1 is one bus cycle of the requested size at the given address. It is never split, and it is stretched only by R5 waits. Kind codes 0 (data) and 1 (stack pull) follow R2 to R5.
- R9: `done` is a one-clock pulse in the clock after the last bus cycle. In that clock `rdata` holds the assembled read data: the full word, the R3 byte pair, or {8'h00, byte} for byte reads. It is 0 for writes and free cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_waits | input | NUM_CS*WAIT_W | Wait-state field per chip-select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 3 | 0 data, 1 stack pull, 2 vector, 3 conditional, 4 free |
| req_region | input | 2 | 0 internal, 1 8-bit external, 2 slow chip-select, 3 16-bit external |
| req_cs | input | CS_W | Chip-select index for region 2 |
| req_cond_real | input | 1 | Conditional cycle becomes a real access |
| req_wdata | input | 16 | Write data |
| mem_en | output | 1 | Memory strobe |
| mem_we | output | 1 | Write strobe qualifier |
| mem_byte | output | 1 | 1 = byte cycle on bits 7:0 |
| mem_addr | output | ADDR_W | Bus cycle address |
| mem_wdata | output | 16 | Bus cycle write data |
| mem_rdata | input | 16 | Read data, sampled in the last clock of each bus cycle |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Assembled read data, valid with done |

## Verification
Two functions can fall in the same clock. The first pair is the last wait clock of the first byte of a split slow-region word and the address step to its second byte. The bench provokes this with odd-address words to a chip-select holding three wait states, and judges that every stretched clock keeps its address and that the step comes exactly after 1+W clocks. The second pair is the done pulse and a new request held on the pins. The bench keeps `req_valid` high with altered fields through a whole access, and judges that the bus trace matches the first request alone and that acceptance waits for idle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int BSC_DW = 16;
  localparam int BSC_BW = BSC_DW / 2;

  typedef enum logic [2:0] {
    K_DATA = 3'd0,
    K_PULL = 3'd1,
    K_VEC  = 3'd2,
    K_COND = 3'd3,
    K_FREE = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    RG_INT   = 2'd0,
    RG_EXT8  = 2'd1,
    RG_SLOW  = 2'd2,
    RG_EXT16 = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CAP_WORD = 2'd0,
    CAP_HI   = 2'd1,
    CAP_LO   = 2'd2
  } cap_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic split;
    logic word;
    logic write;
    logic no_strobe;
  } plan_flags_t;
endpackage

// File: rtl/bsc_planner.sv
module bsc_planner
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CS = 2,
  parameter int WAIT_W = 2,
  parameter int CS_W   = 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     word,
  input  logic                     write,
  input  logic [2:0]               kind,
  input  logic [1:0]               region,
  input  logic [CS_W-1:0]          cs_sel,
  input  logic                     cond_real,
  input  logic [NUM_CS*WAIT_W-1:0] cfg_waits,
  output plan_flags_t              flags,
  output logic [ADDR_W-1:0]        eff_addr,
  output logic [WAIT_W-1:0]        waits
);
  logic [WAIT_W-1:0] wtab [NUM_CS];
  logic [WAIT_W-1:0] cs_wait;
  logic is_vec, is_cond, quiet, word_eff, mis_ok;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_wtab
    assign wtab[g] = cfg_waits[g*WAIT_W +: WAIT_W];
  end

  always_comb begin
    cs_wait = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_sel == CS_W'(i)) cs_wait = wtab[i];
    end
  end

  assign is_vec   = (kind == K_VEC);
  assign is_cond  = (kind == K_COND);
  assign quiet    = (kind == K_FREE) || (is_cond && !cond_real);
  assign word_eff = word || is_vec;
  assign mis_ok   = (region == RG_INT);
  assign eff_addr = is_vec ? {addr[ADDR_W-1:1], 1'b0} : addr;

  always_comb begin
    flags.no_strobe = quiet;
    flags.word      = word_eff;
    flags.write     = write && !is_vec;
    flags.split     = word_eff && !quiet && !is_cond &&
                      ((region == RG_EXT8) || (eff_addr[0] && !mis_ok));
  end

  assign waits = ((region == RG_SLOW) && !quiet) ? cs_wait : '0;
endmodule

// File: rtl/bsc_sequencer.sv
module bsc_sequencer
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  plan_flags_t       pf,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [WAIT_W-1:0] waits,
  input  logic [BSC_DW-1:0] wdata,
  output logic              ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BSC_DW-1:0] mem_wdata,
  output logic              cap_en,
  output cap_mode_e         cap_mode,
  output logic              done
);
  seq_state_e        st;
  plan_flags_t       r_pf;
  logic [ADDR_W-1:0] r_addr;
  logic [WAIT_W-1:0] r_waits, wcnt;
  logic [BSC_DW-1:0] r_wdata;
  logic              piece, run, piece_end;
  logic [BSC_BW-1:0] lane_byte;

  assign run       = (st == S_RUN);
  assign piece_end = (wcnt == r_waits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_pf    <= '0;
      r_addr  <= '0;
      r_waits <= '0;
      r_wdata <= '0;
      piece   <= 1'b0;
      wcnt    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          r_pf    <= pf;
          r_addr  <= eff_addr;
          r_waits <= waits;
          r_wdata <= wdata;
          piece   <= 1'b0;
          wcnt    <= '0;
          st      <= S_RUN;
        end
        S_RUN: begin
          if (piece_end) begin
            if (r_pf.split && !piece) begin
              piece <= 1'b1;
              wcnt  <= '0;
            end else begin
              st <= S_FIN;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (r_pf.split) lane_byte = piece ? r_wdata[BSC_BW-1:0] : r_wdata[BSC_DW-1:BSC_BW];
    else            lane_byte = r_wdata[BSC_BW-1:0];
  end

  assign ready     = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_en    = run && !r_pf.no_strobe;
  assign mem_we    = run && r_pf.write && !r_pf.no_strobe;
  assign mem_byte  = r_pf.split || !r_pf.word;
  assign mem_addr  = r_addr + ADDR_W'(piece);
  assign mem_wdata = (r_pf.word && !r_pf.split) ? r_wdata : {{BSC_BW{1'b0}}, lane_byte};
  assign cap_en    = run && piece_end && !r_pf.write && !r_pf.no_strobe;

  always_comb begin
    if (!r_pf.split) cap_mode = r_pf.word ? CAP_WORD : CAP_LO;
    else             cap_mode = piece ? CAP_LO : CAP_HI;
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en) && ($past(wcnt) != $past(r_waits))) |-> $stable(mem_addr));

  assert_split_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && piece && !$past(piece)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mem_en && !done));
endmodule

// File: rtl/bsc_assembler.sv
module bsc_assembler
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  cap_mode_e         cap_mode,
  input  logic [BSC_DW-1:0] mem_rdata,
  output logic [BSC_DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clear) begin
      rdata <= '0;
    end else if (cap_en) begin
      unique case (cap_mode)
        CAP_WORD: rdata <= mem_rdata;
        CAP_HI:   rdata[BSC_DW-1:BSC_BW] <= mem_rdata[BSC_BW-1:0];
        CAP_LO:   rdata[BSC_BW-1:0] <= mem_rdata[BSC_BW-1:0];
        default:  rdata <= rdata;
      endcase
    end
  end
endmodule

// File: rtl/bus_stretch_ctrl.sv
module bus_stretch_ctrl
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CS = 2,
  parameter int WAIT_W = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CS*WAIT_W-1:0] cfg_waits,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_word,
  input  logic                     req_write,
  input  logic [2:0]               req_kind,
  input  logic [1:0]               req_region,
  input  logic [CS_W-1:0]          req_cs,
  input  logic                     req_cond_real,
  input  logic [BSC_DW-1:0]        req_wdata,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic                     mem_byte,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [BSC_DW-1:0]        mem_wdata,
  input  logic [BSC_DW-1:0]        mem_rdata,
  output logic                     done,
  output logic [BSC_DW-1:0]        rdata
);
  plan_flags_t       pf;
  logic [ADDR_W-1:0] eff_addr;
  logic [WAIT_W-1:0] waits;
  logic              accept, cap_en;
  cap_mode_e         cap_mode;

  assign accept = req_valid && req_ready;

  bsc_planner #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .CS_W(CS_W)) u_plan (
    .addr(req_addr), .word(req_word), .write(req_write), .kind(req_kind),
    .region(req_region), .cs_sel(req_cs), .cond_real(req_cond_real),
    .cfg_waits(cfg_waits), .flags(pf), .eff_addr(eff_addr), .waits(waits)
  );

  bsc_sequencer #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .pf(pf), .eff_addr(eff_addr),
    .waits(waits), .wdata(req_wdata), .ready(req_ready), .mem_en(mem_en),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cap_en(cap_en), .cap_mode(cap_mode), .done(done)
  );

  bsc_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap_en(cap_en),
    .cap_mode(cap_mode), .mem_rdata(mem_rdata), .rdata(rdata)
  );

  assert_free_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pf.no_strobe) |=> (!mem_en && $past(accept)));

  assert_accept_then_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/sim_bus_stretch_ctrl.sv
`timescale 1ns/1ps
module sim_bus_stretch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_waits = 4'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_word = 1'b0, req_write = 1'b0, req_cs = 1'b0, req_cond_real = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [1:0]  req_region = '0;
  logic [15:0] req_wdata = '0;
  logic        mem_en, mem_we, mem_byte, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] memval(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h11};
  endfunction

  assign mem_rdata = memval(mem_addr);

  bus_stretch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_waits(cfg_waits), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_word(req_word),
    .req_write(req_write), .req_kind(req_kind), .req_region(req_region),
    .req_cs(req_cs), .req_cond_real(req_cond_real), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .rdata(rdata)
  );

  typedef struct {
    logic        en, we, byt, dn;
    logic [15:0] a, wd, rd;
  } exp_t;
  exp_t rec_q[$];

  function automatic void cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endfunction

  task automatic check_idle(input string tag);
    cmp($sformatf("R1 %s idle ready", tag), {15'd0, req_ready}, 16'd1);
    cmp($sformatf("R1 %s idle mem_en", tag), {15'd0, mem_en}, 16'd0);
    cmp($sformatf("R9 %s idle done", tag), {15'd0, done}, 16'd0);
  endtask

  task automatic issue(input string tag, input logic [15:0] a, input logic w, input logic wr,
                       input logic [2:0] k, input logic [1:0] rg, input logic cs,
                       input logic cr, input logic [15:0] wd, input logic hold);
    logic vec, quiet, ww, wrr, sp;
    logic [15:0] ea, v0, v1, rd;
    int nw, np, idx;
    exp_t r;
    vec   = (k == 3'd2);
    quiet = (k == 3'd4) || (k == 3'd3 && !cr);
    ww    = w || vec;
    wrr   = wr && !vec;
    ea    = vec ? (a & 16'hFFFE) : a;
    sp    = ww && !quiet && (k != 3'd3) && (rg == 2'd1 || (ea[0] && rg != 2'd0));
    nw    = (rg == 2'd2 && !quiet) ? int'(cs ? cfg_waits[3:2] : cfg_waits[1:0]) : 0;
    np    = sp ? 2 : 1;
    rec_q.delete();
    for (int p = 0; p < np; p++) begin
      for (int c = 0; c <= nw; c++) begin
        r.en  = !quiet;
        r.we  = wrr;
        r.byt = sp || !ww;
        r.a   = ea + 16'(p);
        r.wd  = sp ? {8'h00, (p == 1) ? wd[7:0] : wd[15:8]} : (ww ? wd : {8'h00, wd[7:0]});
        r.dn  = 1'b0;
        r.rd  = '0;
        rec_q.push_back(r);
      end
    end
    v0 = memval(ea);
    v1 = memval(ea + 16'd1);
    if (wrr || quiet) rd = '0;
    else if (sp)      rd = {v0[7:0], v1[7:0]};
    else if (ww)      rd = v0;
    else              rd = {8'h00, v0[7:0]};
    r.en = 1'b0; r.we = 1'b0; r.byt = 1'b0; r.a = '0; r.wd = '0; r.dn = 1'b1; r.rd = rd;
    rec_q.push_back(r);

    @(negedge clk);
    check_idle(tag);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_kind = k;
    req_region = rg; req_cs = cs; req_cond_real = cr; req_wdata = wd;
    idx = 0;
    while (rec_q.size() > 0) begin
      r = rec_q.pop_front();
      @(negedge clk);
      if (idx == 0) begin
        if (hold) begin
          req_addr = ~a; req_word = ~w; req_region = ~rg; req_wdata = ~wd;
        end else begin
          req_valid = 1'b0;
        end
      end
      cmp($sformatf("R1 %s busy ready c%0d", tag, idx), {15'd0, req_ready}, 16'd0);
      cmp($sformatf("%s mem_en c%0d", tag, idx), {15'd0, mem_en}, {15'd0, r.en});
      cmp($sformatf("R9 %s done c%0d", tag, idx), {15'd0, done}, {15'd0, r.dn});
      if (r.en) begin
        cmp($sformatf("%s mem_we c%0d", tag, idx), {15'd0, mem_we}, {15'd0, r.we});
        cmp($sformatf("%s mem_byte c%0d", tag, idx), {15'd0, mem_byte}, {15'd0, r.byt});
        cmp($sformatf("%s mem_addr c%0d", tag, idx), mem_addr, r.a);
        if (r.we) cmp($sformatf("%s mem_wdata c%0d", tag, idx), mem_wdata, r.wd);
      end
      if (r.dn) begin
        cmp($sformatf("R9 %s rdata", tag), rdata, r.rd);
        req_valid = 1'b0;
      end
      idx++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_waits = {2'd3, 2'd1};
    repeat (3) @(negedge clk);
    check_idle("reset R1");
    rst_n = 1'b1;
    // R2: internal RAM, aligned and odd word, byte
    issue("R2 int word", 16'h0100, 1, 0, 3'd0, 2'd0, 0, 0, 16'h0, 0);
    issue("R2 int odd word wr", 16'h0123, 1, 1, 3'd1, 2'd0, 0, 0, 16'hBEEF, 0);
    issue("R2 int byte", 16'h0045, 0, 0, 3'd0, 2'd0, 0, 0, 16'h0, 0);
    // R3: 8-bit external split order
    issue("R3 ext8 word rd", 16'h2040, 1, 0, 3'd0, 2'd1, 0, 0, 16'h0, 0);
    issue("R3 ext8 word wr", 16'h2051, 1, 1, 3'd0, 2'd1, 0, 0, 16'hC3A7, 0);
    issue("R3 ext8 byte wr", 16'h2077, 0, 1, 3'd0, 2'd1, 0, 0, 16'h12F0, 0);
    // R4: misaligned words to non-internal memories
    issue("R4 ext16 odd rd", 16'h3001, 1, 0, 3'd0, 2'd3, 0, 0, 16'h0, 0);
    issue("R4 ext16 even rd", 16'h3002, 1, 0, 3'd1, 2'd3, 0, 0, 16'h0, 0);
    issue("R4 slow odd wr", 16'h40FF, 1, 1, 3'd0, 2'd2, 1, 0, 16'h5A69, 0);
    // R5: slow chip-select waits
    issue("R5 cs0 word rd", 16'h4010, 1, 0, 3'd0, 2'd2, 0, 0, 16'h0, 0);
    issue("R5 cs1 byte wr", 16'h4011, 0, 1, 3'd0, 2'd2, 1, 0, 16'h0077, 0);
    issue("R5 cs1 odd rd", 16'h4033, 1, 0, 3'd1, 2'd2, 1, 0, 16'h0, 0);
    cfg_waits = {2'd0, 2'd2};
    issue("R5 cs1 zero wait", 16'h4020, 1, 0, 3'd0, 2'd2, 1, 0, 16'h0, 0);
    issue("R5 cs0 two wait", 16'h4022, 0, 0, 3'd0, 2'd2, 0, 0, 16'h0, 0);
    // R6: vector fetch
    issue("R6 vec ext8 odd", 16'hFFF7, 0, 1, 3'd2, 2'd1, 0, 0, 16'h1111, 0);
    issue("R6 vec int", 16'hFFFD, 0, 0, 3'd2, 2'd0, 0, 0, 16'h0, 0);
    // R7: free and unreal conditional cycles
    issue("R7 free slow", 16'h4001, 1, 1, 3'd4, 2'd2, 0, 0, 16'hFFFF, 0);
    issue("R7 cond idle ext8", 16'h2001, 1, 0, 3'd3, 2'd1, 0, 0, 16'h0, 0);
    // R8: real conditional cycles
    issue("R8 cond ext8 word", 16'h2100, 1, 0, 3'd3, 2'd1, 0, 1, 16'h0, 0);
    issue("R8 cond slow odd wr", 16'h4101, 1, 1, 3'd3, 2'd2, 0, 1, 16'hA1B2, 0);
    issue("R8 cond ext16 odd", 16'h3005, 1, 0, 3'd3, 2'd3, 0, 1, 16'h0, 0);
    // R1: request held with changed fields while busy
    cfg_waits = {2'd3, 2'd3};
    issue("R1 hold slow", 16'h4041, 1, 0, 3'd0, 2'd2, 0, 0, 16'h0, 1);
    issue("R1 hold ext8", 16'h2202, 1, 1, 3'd0, 2'd1, 1, 0, 16'h9876, 1);
    @(negedge clk);
    check_idle("R1 final");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule